// File: doc/BRIEF.md
# Byte-Lane Parallel I/O Port Pair

This block sits on a 16-bit processor bus that keeps I/O space apart from memory space. It watches the address, a space-select line, an active-low high-byte enable and active-low read and write strobes. From these it serves two fixed 16-bit ports. The input port presents two 8-bit switch groups to the bus. The output port holds two 8-bit registers that drive LEDs.

Each 8-bit half of the data bus is selected on its own, so software can use either byte or word accesses. Address bit 0 low selects the low lane. The high-byte enable low selects the high lane. A tri-state bus driver is modelled as a per-lane output-enable bit together with a data-out bus. Strobes are assumed to be sampled once per clock.

Top module: `byte_lane_io`

## Requirements
- R1: When `mem_sel` is 1, the access targets memory space. No lane enable rises and no output register changes, whatever the address and strobes are.
- R2: The low lane (bits 7:0) takes part when `addr[0]` is 0. The high lane (bits 15:8) takes part when `bhe_n` is 0. An odd address with `bhe_n` at 1 touches neither lane.
- R3: The input port decodes only at addresses 0x0006 and 0x0007. Every other address, including ones that differ only in bits 15:3, leaves both lane enables at 0.
- R4: The output port decodes only at addresses 0x0004 and 0x0005. A write to any other address leaves `led_out` unchanged.
- R5: `bus_oe[k]` is 1 only while `rd_n` is 0 and lane k of the input port is selected. In that case the matching byte of `bus_dout` equals the matching byte of `sw_in`. A lane whose enable is 0 drives zero on its `bus_dout` byte.
- R6: A selected output lane loads its byte of `bus_din` at a rising clock edge where `wr_n` is 0. A lane that is not selected keeps its value.
- R7: A word write to 0x0004 with `bhe_n` at 0 places `bus_din[7:0]` in `led_out[7:0]` and `bus_din[15:8]` in `led_out[15:8]`. A high-byte write to 0x0005 takes its data from `bus_din[15:8]`.
- R8: `led_out` is 0 after a clock edge with `rst_n` at 0. Afterwards it holds until the next matching write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Bus address |
| mem_sel | input | 1 | 1 = memory space, 0 = I/O space |
| bhe_n | input | 1 | Active-low high-byte enable |
| rd_n | input | 1 | Active-low I/O read strobe |
| wr_n | input | 1 | Active-low I/O write strobe |
| bus_din | input | 16 | Data driven by the processor during writes |
| sw_in | input | 16 | Switch levels; high group in bits 15:8 |
| bus_dout | output | 16 | Data the port places on the bus during reads |
| bus_oe | output | 2 | Per-lane bus drive enable; bit 1 is the high lane |
| led_out | output | 16 | Output register contents |

## Verification
The bench builds the block with its default parameters: 16 address bits, 8-bit lanes, the input port at 0x0006 and the output port at 0x0004. With these values the bench can reach every lane combination at both ports: even bytes, odd bytes, words, and the odd-address case with the high enable off. It also reaches near-miss addresses that differ from a port address only in upper bits, and addresses that point at the other port. A behavioural model predicts the enables, the read data and the register contents. The bench compares all of them against the outputs on every clock, through back-to-back writes, reads and a reset in the middle of the run.

// File: rtl/byte_lane_io_pkg.sv
// Shared types for the byte-lane I/O port pair.
// Assumes a bus of exactly two byte lanes.
package byte_lane_io_pkg;
    typedef struct packed {
        logic hi;   // high lane taking part
        logic lo;   // low lane taking part
    } lane_sel_t;
endpackage

// File: rtl/blio_decode.sv
// Address and lane decoder for one 16-bit port of two consecutive byte addresses.
// Assumes BASE is even. It matches on the address bits above bit 0 and
// selects lanes from bit 0 and the active-low high-byte enable.
module blio_decode
    import byte_lane_io_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter logic [15:0] BASE   = 16'h0006
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_sel,
    input  logic              bhe_n,
    output lane_sel_t         sel
);
    localparam logic [ADDR_W-2:0] PAIR = BASE[ADDR_W-1:1];

    logic hit;

    // Port hit: I/O space and matching even/odd address pair.
    always_comb begin
        hit    = !mem_sel && (addr[ADDR_W-1:1] == PAIR);
        sel.lo = hit && !addr[0];
        sel.hi = hit && !bhe_n;
    end
endmodule

// File: rtl/blio_in_lane.sv
// One byte lane of the input port: a modelled tri-state driver.
// Assumes the enable already includes the read strobe.
module blio_in_lane #(
    parameter int W = 8
) (
    input  logic         en,
    input  logic [W-1:0] sw,
    output logic         oe,
    output logic [W-1:0] dout
);
    // Drive the switch byte only while enabled; drive zero otherwise.
    always_comb begin
        oe   = en;
        dout = en ? sw : '0;
    end
endmodule

// File: rtl/blio_out_lane.sv
// One byte lane of the output port: a clocked register feeding LEDs.
// Assumes the write strobe is stable around the sampling clock edge.
module blio_out_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Clear on reset; otherwise load on write and hold at all other times.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end
endmodule

// File: rtl/byte_lane_io.sv
// Byte-lane I/O port pair: a 16-bit switch input port and a 16-bit LED
// output port on a two-lane processor bus. Both lanes are decoded
// independently, so byte and word accesses work at both ports.
// Assumes strobes last at least one clock and the port bases are even.
module byte_lane_io
    import byte_lane_io_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter int          LANE_W  = 8,
    parameter logic [15:0] IN_BASE  = 16'h0006,
    parameter logic [15:0] OUT_BASE = 16'h0004
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  mem_sel,
    input  logic                  bhe_n,
    input  logic                  rd_n,
    input  logic                  wr_n,
    input  logic [2*LANE_W-1:0]   bus_din,
    input  logic [2*LANE_W-1:0]   sw_in,
    output logic [2*LANE_W-1:0]   bus_dout,
    output logic [1:0]            bus_oe,
    output logic [2*LANE_W-1:0]   led_out
);
    localparam int LANES = 2;

    lane_sel_t        in_sel, out_sel;
    logic [LANES-1:0] rd_en, wr_en;

    blio_decode #(.ADDR_W(ADDR_W), .BASE(IN_BASE)) u_dec_in (
        .addr(addr), .mem_sel(mem_sel), .bhe_n(bhe_n), .sel(in_sel)
    );

    blio_decode #(.ADDR_W(ADDR_W), .BASE(OUT_BASE)) u_dec_out (
        .addr(addr), .mem_sel(mem_sel), .bhe_n(bhe_n), .sel(out_sel)
    );

    // Qualify lane selects with the read and write strobes.
    always_comb begin
        rd_en = {in_sel.hi,  in_sel.lo}  & {LANES{!rd_n}};
        wr_en = {out_sel.hi, out_sel.lo} & {LANES{!wr_n}};
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        blio_in_lane #(.W(LANE_W)) u_in (
            .en   (rd_en[g]),
            .sw   (sw_in[g*LANE_W +: LANE_W]),
            .oe   (bus_oe[g]),
            .dout (bus_dout[g*LANE_W +: LANE_W])
        );
        blio_out_lane #(.W(LANE_W)) u_out (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (wr_en[g]),
            .d    (bus_din[g*LANE_W +: LANE_W]),
            .q    (led_out[g*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/byte_lane_io_chk.sv
// Property checker for byte_lane_io, attached by bind below.
module byte_lane_io_chk #(
    parameter int ADDR_W = 16,
    parameter int LANE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   addr,
    input logic                mem_sel,
    input logic                bhe_n,
    input logic                rd_n,
    input logic                wr_n,
    input logic [2*LANE_W-1:0] bus_dout,
    input logic [1:0]          bus_oe,
    input logic [2*LANE_W-1:0] led_out
);
    AST_MEM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel |-> bus_oe == 2'b00);  // R1
    AST_MEM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel |=> $stable(led_out));  // R1
    AST_HI_NEEDS_BHE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe[1] |-> !bhe_n);  // R2
    AST_LO_NEEDS_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe[0] |-> !addr[0]);  // R2
    AST_NO_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> (bus_oe == 2'b00 && bus_dout == '0));  // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_n |=> $stable(led_out));  // R6
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> led_out == '0);  // R8
endmodule

bind byte_lane_io byte_lane_io_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mem_sel(mem_sel), .bhe_n(bhe_n),
    .rd_n(rd_n), .wr_n(wr_n), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .led_out(led_out)
);

// File: tb/sim_byte_lane_io.sv
module sim_byte_lane_io;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] addr = 0;
    logic        mem_sel = 0, bhe_n = 1, rd_n = 1, wr_n = 1;
    logic [15:0] bus_din = 0, sw_in = 0;
    logic [15:0] bus_dout, led_out;
    logic [1:0]  bus_oe;

    int    compared = 0, mismatched = 0;
    string cur_req = "R8";
    bit    done = 0;
    logic [15:0] m_led = 0;

    always #4 clk = ~clk;

    byte_lane_io u0 (.*);

    // Behavioural model of the output registers.
    always @(posedge clk) begin
        if (!rst_n) m_led <= 16'h0;
        else if (!mem_sel && !wr_n) begin
            if (addr == 16'h0004) m_led[7:0] <= bus_din[7:0];
            if ((addr == 16'h0004 || addr == 16'h0005) && !bhe_n)
                m_led[15:8] <= bus_din[15:8];
        end
    end

    // Compare every output against the model at each falling edge.
    always @(negedge clk) begin
        logic [1:0]  e_oe;
        logic [15:0] e_do;
        e_oe = 2'b00;
        if (!mem_sel && !rd_n) begin
            e_oe[0] = (addr == 16'h0006);
            e_oe[1] = !bhe_n && (addr == 16'h0006 || addr == 16'h0007);
        end
        e_do = {e_oe[1] ? sw_in[15:8] : 8'h00, e_oe[0] ? sw_in[7:0] : 8'h00};
        if (!done) begin
            compared++;
            if (bus_oe !== e_oe || bus_dout !== e_do || led_out !== m_led) begin
                mismatched++;
                $display("FAIL %s: oe=%b dout=%h led=%h expected oe=%b dout=%h led=%h",
                         cur_req, bus_oe, bus_dout, led_out, e_oe, e_do, m_led);
            end
        end
    end

    task automatic op(input string req, input logic ms, input logic [15:0] a,
                      input logic bh, input logic r, input logic w,
                      input logic [15:0] d, input logic [15:0] s);
        @(posedge clk); #1;
        cur_req = req; mem_sel = ms; addr = a; bhe_n = bh;
        rd_n = r; wr_n = w; bus_din = d; sw_in = s;
    endtask

    task automatic idle(input string req);
        op(req, 0, 16'h0000, 1, 1, 1, 16'h0, sw_in);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;                                          // R8 reset state seen
        op("R7", 0, 16'h0004, 0, 1, 0, 16'hA5C3, 16'h0);       // word write
        idle("R7");
        op("R6", 0, 16'h0004, 1, 1, 0, 16'h1122, 16'h0);       // low byte only
        idle("R6");
        op("R2", 0, 16'h0005, 0, 1, 0, 16'h77EE, 16'h0);       // high byte write
        idle("R2");
        op("R2", 0, 16'h0005, 1, 1, 0, 16'h9999, 16'h0);       // odd, no bhe: nothing
        op("R1", 1, 16'h0004, 0, 1, 0, 16'hDEAD, 16'h0);       // memory space
        op("R4", 0, 16'h1004, 0, 1, 0, 16'hBEEF, 16'h0);       // near-miss address
        op("R4", 0, 16'h0006, 0, 1, 0, 16'hBEEF, 16'h0);       // input port address
        idle("R8");                                            // hold
        op("R3", 0, 16'h0006, 0, 0, 1, 16'h0, 16'h1234);       // word read
        op("R3", 0, 16'h0006, 1, 0, 1, 16'h0, 16'h5678);       // low byte read
        op("R2", 0, 16'h0007, 0, 0, 1, 16'h0, 16'h9ABC);       // high byte read
        op("R2", 0, 16'h0007, 1, 0, 1, 16'h0, 16'h9ABC);       // odd, no bhe
        op("R3", 0, 16'h0106, 0, 0, 1, 16'h0, 16'hFFFF);       // near-miss
        op("R1", 1, 16'h0006, 0, 0, 1, 16'h0, 16'hFFFF);       // memory read
        op("R5", 0, 16'h0006, 0, 1, 1, 16'h0, 16'hFFFF);       // no strobe
        op("R4", 0, 16'h0004, 0, 0, 1, 16'h0, 16'hFFFF);       // read at output port
        for (int i = 0; i < 64; i++) begin
            logic [15:0] a;
            a = (i % 3 == 0) ? 16'h0004 : (i % 3 == 1) ? 16'h0005 : 16'h0006;
            op("R6", i[5], a, i[1], i[2], i[3], 16'h1111 * i[3:0] ^ 16'h0F0F, 16'h3C3C + i[15:0]);
        end
        op("R8", 0, 16'h0004, 0, 1, 0, 16'h4242, 16'h0);
        @(posedge clk); #1 rst_n = 0; cur_req = "R8";
        @(posedge clk); #1 rst_n = 1;
        idle("R8");
        op("R7", 0, 16'h0004, 0, 1, 0, 16'h0FF0, 16'h0);
        idle("R7");
        @(posedge clk); @(negedge clk); #1;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule